// File: doc/BRIEF.md
# Banked Microcontroller Data Memory Controller

This block holds the internal data memory of an 8-bit microcontroller core and decodes every core access to it. A 256-byte internal RAM is reached in four ways: as one of eight working registers in a bank chosen by two bank-select bits, as a directly addressed byte in the lower half, as an indirectly addressed byte anywhere in the 256, or as a single bit inside a sixteen-byte bit window. A separate expanded RAM (1024 bytes by default) serves the move-external access kind. Its usable size can be cut down in quarter steps, or it can be switched off entirely so that every such access goes to the external bus.

Each access is offered for one cycle with `req_valid` high. The block never applies back-pressure: it takes one access per cycle, and exactly one cycle later it presents the response with `rsp_valid` high. The consumer must take that response in that cycle, because the block holds no queue. Direct accesses to the upper half are not served from RAM. The block flags them so that the special-function register file can claim them. Move-external accesses that miss the on-chip expanded RAM are flagged for the external bus interface. Reset clears only the response pipeline. The RAM arrays keep whatever they hold.

Top module: `dmem_ctrl`

## Requirements
- R1: While `rst_n` is low, `rsp_valid`, `rsp_sfr`, `rsp_ext` and `rsp_bit` are all 0.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `req_kind` uses the codes 0 register, 1 direct, 2 indirect, 3 bit and 4 move-external. Codes 5 to 7 change no memory and return `rsp_rdata` 0 with every flag low.
- R3: A register access uses internal byte `{bank_sel, req_addr[2:0]}`. The other address bits are ignored.
- R4: Direct and indirect accesses to addresses 00h–7Fh reach the same bytes.
- R5: A direct access with `req_addr[7]`=1 raises `rsp_sfr`, returns `rsp_rdata` 0 and writes no RAM byte.
- R6: An indirect access with `req_addr[7]`=1 reads and writes internal bytes 80h–FFh.
- R7: A bit access with `req_addr[7]`=0 and bit number b=`req_addr[6:0]` targets byte 20h+b[6:3], bit b[2:0]. A write stores `req_wdata[0]` into that bit alone. `rsp_bit` returns the bit's previous value and `rsp_rdata` returns the whole previous byte. A bit access with `req_addr[7]`=1 raises `rsp_sfr` instead.
- R8: Every access that reaches a RAM byte returns that byte's value from before the access, including when the access writes it.
- R9: A move-external access with `xram_off`=0 and address below (`xram_size`+1)×256 reads or writes the expanded RAM. `xram_size` codes 0, 1, 2 and 3 give 256, 512, 768 and 1024 bytes.
- R10: A move-external access at or above that limit, or made with `xram_off`=1, raises `rsp_ext`, returns `rsp_rdata` 0 and writes no expanded RAM byte.
- R11: Reset leaves the contents of both RAMs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the response pipeline |
| req_valid | input | 1 | An access is offered this cycle |
| req_kind | input | 3 | Access kind code |
| req_addr | input | 16 | Access address (register, byte, bit or expanded) |
| req_wdata | input | 8 | Write data; bit 0 is used for bit writes |
| req_we | input | 1 | Access writes |
| bank_sel | input | 2 | Register bank select |
| xram_off | input | 1 | 1 sends all move-external accesses to the external bus |
| xram_size | input | 2 | Expanded RAM size code |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 8 | Byte value before the access |
| rsp_bit | output | 1 | Bit value before a bit access |
| rsp_sfr | output | 1 | Access belongs to the special-function register space |
| rsp_ext | output | 1 | Access belongs to the external bus |

## Verification
A corrupted bank or bit-window decode leaves the array unharmed but puts the data in the wrong byte. That shows up only on a later readback through a different access kind, so the stimulus writes through one kind and reads through another. A wrong bit merge disturbs neighbouring bits, which the next byte read of the window exposes one cycle after it is issued. Size-limit or enable faults appear in the very next response as a wrong external flag or as expanded RAM data that should have stayed untouched.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [2:0] {
    KIND_REG  = 3'd0,
    KIND_DIR  = 3'd1,
    KIND_IND  = 3'd2,
    KIND_BIT  = 3'd3,
    KIND_XMOV = 3'd4
  } kind_e;

  localparam int unsigned BIT_WIN_BASE = 32'h20;
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned IRAM_AW    = 8,
  parameter int unsigned XRAM_BYTES = 1024,
  parameter int unsigned XRAM_AW    = $clog2(XRAM_BYTES)
) (
  input  logic [2:0]          kind,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          bank,
  input  logic                xoff,
  input  logic [1:0]          xsize,
  output logic                iram_hit,
  output logic [IRAM_AW-1:0]  iram_addr,
  output logic                is_bit,
  output logic [2:0]          bit_pos,
  output logic                sfr_hit,
  output logic                xram_hit,
  output logic [XRAM_AW-1:0]  xram_addr,
  output logic                ext_hit
);
  localparam int unsigned XSTEP = XRAM_BYTES / 4;
  localparam int unsigned LIM_W = ADDR_W + 2;

  logic [LIM_W-1:0] xlimit;
  logic             upper;

  assign upper     = addr[IRAM_AW-1];
  assign xlimit    = LIM_W'((32'(xsize) + 32'd1) * XSTEP);
  assign xram_addr = addr[XRAM_AW-1:0];

  always_comb begin
    iram_hit  = 1'b0;
    iram_addr = '0;
    is_bit    = 1'b0;
    bit_pos   = addr[2:0];
    sfr_hit   = 1'b0;
    xram_hit  = 1'b0;
    ext_hit   = 1'b0;
    case (kind)
      KIND_REG: begin
        iram_hit  = 1'b1;
        iram_addr = IRAM_AW'({bank, addr[2:0]});
      end
      KIND_DIR: begin
        sfr_hit   = upper;
        iram_hit  = !upper;
        iram_addr = addr[IRAM_AW-1:0];
      end
      KIND_IND: begin
        iram_hit  = 1'b1;
        iram_addr = addr[IRAM_AW-1:0];
      end
      KIND_BIT: begin
        sfr_hit   = upper;
        iram_hit  = !upper;
        is_bit    = !upper;
        iram_addr = IRAM_AW'(BIT_WIN_BASE) + IRAM_AW'(addr[6:3]);
      end
      KIND_XMOV: begin
        xram_hit = !xoff && ({2'b00, addr} < xlimit);
        ext_hit  = !xram_hit;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dmem_iram.sv
module dmem_iram #(
  parameter int unsigned BYTES = 256,
  parameter int unsigned AW    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/dmem_xram.sv
module dmem_xram #(
  parameter int unsigned BYTES = 1024,
  parameter int unsigned AW    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (en) begin
      rdata <= mem[addr];
      if (we) mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/dmem_ctrl.sv
module dmem_ctrl
  import dmem_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned IRAM_BYTES = 256,
  parameter int unsigned XRAM_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  input  logic              req_we,
  input  logic [1:0]        bank_sel,
  input  logic              xram_off,
  input  logic [1:0]        xram_size,
  output logic              rsp_valid,
  output logic [7:0]        rsp_rdata,
  output logic              rsp_bit,
  output logic              rsp_sfr,
  output logic              rsp_ext
);
  localparam int unsigned IRAM_AW = $clog2(IRAM_BYTES);
  localparam int unsigned XRAM_AW = $clog2(XRAM_BYTES);

  logic               iram_hit, is_bit, sfr_hit, xram_hit, ext_hit;
  logic [IRAM_AW-1:0] iram_addr;
  logic [XRAM_AW-1:0] xram_addr;
  logic [2:0]         bit_pos;
  logic [7:0]         iram_old, iram_wr, merged, xram_rd;
  logic               iram_we, xram_en;

  logic       sel_x_q;
  logic [7:0] iram_q;

  dmem_decode #(
    .ADDR_W(ADDR_W), .IRAM_AW(IRAM_AW), .XRAM_BYTES(XRAM_BYTES), .XRAM_AW(XRAM_AW)
  ) u_dec (
    .kind(req_kind), .addr(req_addr), .bank(bank_sel), .xoff(xram_off),
    .xsize(xram_size), .iram_hit(iram_hit), .iram_addr(iram_addr),
    .is_bit(is_bit), .bit_pos(bit_pos), .sfr_hit(sfr_hit),
    .xram_hit(xram_hit), .xram_addr(xram_addr), .ext_hit(ext_hit)
  );

  always_comb begin
    merged          = iram_old;
    merged[bit_pos] = req_wdata[0];
  end

  assign iram_wr = is_bit ? merged : req_wdata;
  assign iram_we = req_valid && req_we && iram_hit;
  assign xram_en = req_valid && xram_hit;

  dmem_iram #(.BYTES(IRAM_BYTES), .AW(IRAM_AW)) u_iram (
    .clk(clk), .we(iram_we), .addr(iram_addr), .wdata(iram_wr), .rdata(iram_old)
  );

  dmem_xram #(.BYTES(XRAM_BYTES), .AW(XRAM_AW)) u_xram (
    .clk(clk), .en(xram_en), .we(req_we), .addr(xram_addr),
    .wdata(req_wdata), .rdata(xram_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_sfr   <= 1'b0;
      rsp_ext   <= 1'b0;
      rsp_bit   <= 1'b0;
      sel_x_q   <= 1'b0;
      iram_q    <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_sfr   <= req_valid && sfr_hit;
      rsp_ext   <= req_valid && ext_hit;
      rsp_bit   <= req_valid && is_bit && iram_old[bit_pos];
      sel_x_q   <= xram_en;
      iram_q    <= (req_valid && iram_hit) ? iram_old : '0;
    end
  end

  assign rsp_rdata = sel_x_q ? xram_rd : iram_q;
endmodule

// File: rtl/dmem_chk.sv
module dmem_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_kind,
  input logic [ADDR_W-1:0] req_addr,
  input logic              xram_off,
  input logic              rsp_valid,
  input logic [7:0]        rsp_rdata,
  input logic              rsp_bit,
  input logic              rsp_sfr,
  input logic              rsp_ext
);
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!rsp_valid && !rsp_sfr && !rsp_ext && !rsp_bit);
    end
  end

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_reg_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd0) |=> (!rsp_sfr && !rsp_ext));

  assert_direct_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd1 && req_addr[7]) |=> (rsp_sfr && rsp_rdata == 8'h00));

  assert_bit_needs_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_bit |-> (rsp_valid && !rsp_sfr && !rsp_ext));

  assert_xram_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd4 && xram_off) |=> (rsp_ext && rsp_rdata == 8'h00));
endmodule

bind dmem_ctrl dmem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_addr(req_addr), .xram_off(xram_off), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_bit(rsp_bit), .rsp_sfr(rsp_sfr), .rsp_ext(rsp_ext)
);

// File: tb/sim_dmem_ctrl.sv
module sim_dmem_ctrl;
  localparam logic [2:0] K_REG = 3'd0, K_DIR = 3'd1, K_IND = 3'd2,
                         K_BIT = 3'd3, K_XM  = 3'd4, K_NOP = 3'd5;

  typedef struct packed {
    logic [2:0]  kind;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic        we;
    logic [1:0]  bank;
    logic        off;
    logic [1:0]  sz;
    logic        chk;
    logic [7:0]  erd;
    logic        ebit;
    logic        esfr;
    logic        eext;
    logic [3:0]  rq;
  } vec_t;

  function automatic vec_t mk(logic [2:0] k, logic [15:0] a, logic [7:0] d, logic w,
                              logic [1:0] b, logic o, logic [1:0] s, logic c,
                              logic [7:0] r, logic eb, logic es, logic ee, logic [3:0] q);
    mk = '{k, a, d, w, b, o, s, c, r, eb, es, ee, q};
  endfunction

  localparam int NV = 42;
  localparam vec_t TBL [NV] = '{
    mk(K_IND, 16'h0013, 8'hA5, 1, 0, 0, 3, 0, 8'h00, 0, 0, 0, 4),  // R4 preload
    mk(K_REG, 16'h0003, 8'h00, 0, 2, 0, 3, 1, 8'hA5, 0, 0, 0, 3),  // R3 bank 2
    mk(K_DIR, 16'h0013, 8'h00, 0, 0, 0, 3, 1, 8'hA5, 0, 0, 0, 4),  // R4
    mk(K_REG, 16'h0003, 8'h3C, 1, 0, 0, 3, 0, 8'h00, 0, 0, 0, 3),  // R3 bank 0 write
    mk(K_IND, 16'h0003, 8'h00, 0, 0, 0, 3, 1, 8'h3C, 0, 0, 0, 3),  // R3
    mk(K_REG, 16'h000B, 8'h00, 0, 2, 0, 3, 1, 8'hA5, 0, 0, 0, 3),  // R3 high addr bits ignored
    mk(K_IND, 16'h0080, 8'h77, 1, 0, 0, 3, 0, 8'h00, 0, 0, 0, 6),  // R6
    mk(K_IND, 16'h0080, 8'h00, 0, 0, 0, 3, 1, 8'h77, 0, 0, 0, 6),  // R6
    mk(K_DIR, 16'h0080, 8'h11, 1, 0, 0, 3, 1, 8'h00, 0, 1, 0, 5),  // R5
    mk(K_IND, 16'h0080, 8'h00, 0, 0, 0, 3, 1, 8'h77, 0, 0, 0, 5),  // R5 untouched
    mk(K_DIR, 16'h00FF, 8'h00, 0, 0, 0, 3, 1, 8'h00, 0, 1, 0, 5),  // R5
    mk(K_IND, 16'h0025, 8'h00, 1, 0, 0, 3, 0, 8'h00, 0, 0, 0, 7),  // R7 preload
    mk(K_BIT, 16'h002A, 8'h01, 1, 0, 0, 3, 1, 8'h00, 0, 0, 0, 7),  // R7 set bit 2
    mk(K_IND, 16'h0025, 8'h00, 0, 0, 0, 3, 1, 8'h04, 0, 0, 0, 7),  // R7
    mk(K_BIT, 16'h002A, 8'h00, 0, 0, 0, 3, 1, 8'h04, 1, 0, 0, 7),  // R7
    mk(K_BIT, 16'h002F, 8'h01, 1, 0, 0, 3, 1, 8'h04, 0, 0, 0, 7),  // R7 bit 7
    mk(K_BIT, 16'h002A, 8'h00, 1, 0, 0, 3, 1, 8'h84, 1, 0, 0, 7),  // R7 clear
    mk(K_IND, 16'h0025, 8'h00, 0, 0, 0, 3, 1, 8'h80, 0, 0, 0, 7),  // R7
    mk(K_BIT, 16'h0085, 8'h01, 1, 0, 0, 3, 1, 8'h00, 0, 1, 0, 7),  // R7 upper bit
    mk(K_IND, 16'h0042, 8'h99, 1, 0, 0, 3, 0, 8'h00, 0, 0, 0, 8),  // R8
    mk(K_IND, 16'h0042, 8'h66, 1, 0, 0, 3, 1, 8'h99, 0, 0, 0, 8),  // R8 old data
    mk(K_DIR, 16'h0042, 8'h00, 0, 0, 0, 3, 1, 8'h66, 0, 0, 0, 4),  // R4
    mk(K_XM,  16'h0010, 8'hC3, 1, 0, 0, 3, 0, 8'h00, 0, 0, 0, 9),  // R9
    mk(K_XM,  16'h0010, 8'h00, 0, 0, 0, 3, 1, 8'hC3, 0, 0, 0, 9),  // R9
    mk(K_XM,  16'h03FF, 8'h5A, 1, 0, 0, 3, 0, 8'h00, 0, 0, 0, 9),  // R9
    mk(K_XM,  16'h03FF, 8'h00, 0, 0, 0, 3, 1, 8'h5A, 0, 0, 0, 9),  // R9 top byte
    mk(K_XM,  16'h0400, 8'h00, 0, 0, 0, 3, 1, 8'h00, 0, 0, 1, 10), // R10
    mk(K_XM,  16'h0100, 8'h12, 1, 0, 0, 3, 0, 8'h00, 0, 0, 0, 9),  // R9
    mk(K_XM,  16'h0100, 8'hEE, 1, 0, 0, 0, 1, 8'h00, 0, 0, 1, 10), // R10 size 256
    mk(K_XM,  16'h0100, 8'h00, 0, 0, 0, 3, 1, 8'h12, 0, 0, 0, 10), // R10 untouched
    mk(K_XM,  16'h0010, 8'h00, 0, 0, 0, 0, 1, 8'hC3, 0, 0, 0, 9),  // R9 size 256 hit
    mk(K_XM,  16'h01FF, 8'h3E, 1, 0, 0, 1, 0, 8'h00, 0, 0, 0, 9),  // R9
    mk(K_XM,  16'h01FF, 8'h00, 0, 0, 0, 1, 1, 8'h3E, 0, 0, 0, 9),  // R9 size 512
    mk(K_XM,  16'h0200, 8'h00, 0, 0, 0, 1, 1, 8'h00, 0, 0, 1, 10), // R10
    mk(K_XM,  16'h02FF, 8'h71, 1, 0, 0, 2, 0, 8'h00, 0, 0, 0, 9),  // R9
    mk(K_XM,  16'h02FF, 8'h00, 0, 0, 0, 2, 1, 8'h71, 0, 0, 0, 9),  // R9 size 768
    mk(K_XM,  16'h0300, 8'h00, 0, 0, 0, 2, 1, 8'h00, 0, 0, 1, 10), // R10
    mk(K_XM,  16'h0010, 8'h00, 0, 0, 1, 3, 1, 8'h00, 0, 0, 1, 10), // R10 off
    mk(K_XM,  16'h0010, 8'h00, 1, 0, 1, 3, 1, 8'h00, 0, 0, 1, 10), // R10 off write
    mk(K_XM,  16'h0010, 8'h00, 0, 0, 0, 3, 1, 8'hC3, 0, 0, 0, 10), // R10 untouched
    mk(K_NOP, 16'h0013, 8'h00, 1, 0, 0, 3, 1, 8'h00, 0, 0, 0, 2),  // R2 unused code
    mk(K_IND, 16'h0013, 8'h00, 0, 0, 0, 3, 1, 8'hA5, 0, 0, 0, 2)   // R2 no write
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_we = 1'b0;
  logic [1:0]  bank_sel = '0;
  logic        xram_off = 1'b0;
  logic [1:0]  xram_size = 2'd3;
  logic        rsp_valid, rsp_bit, rsp_sfr, rsp_ext;
  logic [7:0]  rsp_rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dmem_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_we(req_we),
    .bank_sel(bank_sel), .xram_off(xram_off), .xram_size(xram_size),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_bit(rsp_bit),
    .rsp_sfr(rsp_sfr), .rsp_ext(rsp_ext)
  );

  task automatic check(input int rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    req_valid = 1'b1;
    req_kind  = v.kind;
    req_addr  = v.addr;
    req_wdata = v.wd;
    req_we    = v.we;
    bank_sel  = v.bank;
    xram_off  = v.off;
    xram_size = v.sz;
    @(negedge clk);
    check(2, "rsp_valid", int'(rsp_valid), 1);
    check(int'(v.rq), "rsp_sfr", int'(rsp_sfr), int'(v.esfr));
    check(int'(v.rq), "rsp_ext", int'(rsp_ext), int'(v.eext));
    if (v.chk) begin
      check(int'(v.rq), "rsp_rdata", int'(rsp_rdata), int'(v.erd));
      check(int'(v.rq), "rsp_bit", int'(rsp_bit), int'(v.ebit));
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs quiet in reset
    check(1, "rsp_valid in reset", int'(rsp_valid), 0);
    check(1, "flags in reset", int'({rsp_sfr, rsp_ext, rsp_bit}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(2, "idle rsp_valid", int'(rsp_valid), 0);

    for (int i = 0; i < NV; i++) apply(TBL[i]);

    req_valid = 1'b0;
    @(negedge clk);
    check(2, "rsp_valid after idle", int'(rsp_valid), 0);

    // R1 and R11: reset mid-run, contents survive
    req_valid = 1'b1;
    req_kind  = K_DIR;
    req_addr  = 16'h0090;
    rst_n     = 1'b0;
    @(negedge clk);
    check(1, "rsp_valid in reset", int'(rsp_valid), 0);
    check(1, "rsp_sfr in reset", int'(rsp_sfr), 0);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    apply(mk(K_IND, 16'h0013, 8'h00, 0, 0, 0, 3, 1, 8'hA5, 0, 0, 0, 11)); // R11
    apply(mk(K_XM,  16'h0010, 8'h00, 0, 0, 0, 3, 1, 8'hC3, 0, 0, 0, 11)); // R11
    apply(mk(K_REG, 16'h0003, 8'h00, 0, 0, 0, 3, 1, 8'h3C, 0, 0, 0, 11)); // R11
    req_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule